// File: doc/BRIEF.md
# Toggle-Handshake Command Issuer

This block is the requesting end of a command port whose target sits in a different clock domain. A local client gives it a command code and a one-cycle start request. The block writes the code into the low field of an 8-bit control byte. In the same write it inverts a single edge bit. The far side treats any change of that bit, rising or falling, as "a new command is ready". It can capture the code at that moment, because the code is already settled.

Completion also uses a level change. The far side inverts an acknowledge line when it has dealt with the command. For simple commands this happens at once. For memory-access commands it happens only after the access ends, so the wait is not fixed. The block passes the acknowledge through a two-flop synchroniser. When it accepts a command, it records the synchronised level at that moment. It stays busy until the synchronised acknowledge differs from that record, and then gives a one-cycle done pulse.

A second far-side status line, the FIFO-not-empty flag, goes through the same kind of synchroniser and appears directly on an output. Two upper bits of the control byte are general-purpose outputs that the client loads separately. A programmable watchdog counter sets a sticky timeout flag if a command stays outstanding too long.

Top module: `cmd_toggle_issuer`

## Requirements
- R1: When a start request is accepted, control bits 4..0 take the command code at the next rising edge. They hold that value until the next accepted request.
- R2: Control bit 5 is the edge bit. It is 0 after reset and inverts at every accepted start request, and at no other time.
- R3: Control bits 7..6 change only when `sf_load` is high, and then take `sf_val`. Issuing a command leaves them unchanged.
- R4: The acknowledge line (`far_status[0]`) is synchronised by two flops. If the acknowledge changes while a command is outstanding, `done` is high for exactly one cycle, after the third rising edge that follows the change.
- R5: `busy` rises at the edge that accepts a request. It falls only when the synchronised acknowledge differs from the level that was captured at that edge. Completion is therefore relative to the captured level, not to an absolute value.
- R6: A start request while `busy` is high does not touch the control byte. It produces a one-cycle `err_busy` pulse at the next edge.
- R7: `fifo_nempty` follows `far_status[1]` two rising edges later.
- R8: While busy, a cycle counter runs. `timeout` rises at edge `timeout_limit`+1 after acceptance if no completion has happened. It stays high until reset. It does not end the wait, so a late acknowledge still completes the command.
- R9: Reset (synchronous, active high) clears the control byte, the captured acknowledge level, `busy`, `done`, `err_busy` and `timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to issue `code` |
| code | input | 5 | Command code to issue |
| sf_load | input | 1 | Load strobe for the special-function bits |
| sf_val | input | 2 | New value for control bits 7..6 |
| timeout_limit | input | 16 | Watchdog limit in cycles |
| far_status | input | 2 | Asynchronous far-side lines: bit 0 acknowledge, bit 1 FIFO not empty |
| ctrl_byte | output | 8 | Control byte: code 4..0, edge 5, special-function 7..6 |
| busy | output | 1 | A command is outstanding |
| done | output | 1 | One-cycle completion pulse |
| err_busy | output | 1 | One-cycle pulse for a start rejected while busy |
| timeout | output | 1 | Sticky watchdog flag |
| fifo_nempty | output | 1 | Synchronised FIFO-not-empty level |

## Verification
Suppose the captured acknowledge level is wrong. Then `done` either appears one cycle after acceptance, or the block never completes. Either shows within a handful of cycles, against a delay the bench knows exactly. A synchroniser that is too short or too long moves `done` and `fifo_nempty` by one cycle from the three-edge and two-edge counts. An edge bit that fails to invert shows in the control byte right after acceptance, and the far-side model in the bench then never starts its countdown. A watchdog counter that is off by one moves the rise of `timeout` across the boundary cycle that the bench checks on both sides.

// File: rtl/cti_pkg.sv
package cti_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_WAIT = 1'b1} phase_e;
  localparam int FAR_ACK = 0;
  localparam int FAR_FNE = 1;
  localparam int FAR_W   = 2;
endpackage

// File: rtl/cti_sync.sv
module cti_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cti_timer.sv
module cti_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      expired <= 1'b0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (run && !expired) begin
      if (cnt_q == limit) expired <= 1'b1;
      else                cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cti_ctrl_reg.sv
module cti_ctrl_reg #(
  parameter int CODE_W = 5,
  parameter int SF_W   = 2,
  localparam int CTRL_W = CODE_W + 1 + SF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [CODE_W-1:0] code,
  input  logic              sf_load,
  input  logic [SF_W-1:0]   sf_val,
  output logic [CTRL_W-1:0] ctrl
);
  logic [CODE_W-1:0] code_q;
  logic              edge_q;
  logic [SF_W-1:0]   sf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      edge_q <= 1'b0;
    end else if (issue) begin
      code_q <= code;
      edge_q <= ~edge_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          sf_q <= '0;
    else if (sf_load) sf_q <= sf_val;
  end

  assign ctrl = {sf_q, edge_q, code_q};
endmodule

// File: rtl/cti_fsm.sv
module cti_fsm
  import cti_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ack_s,
  output logic issue,
  output logic busy,
  output logic done,
  output logic err_busy
);
  phase_e phase_q;
  logic   ack_ref_q;

  assign busy  = (phase_q == PH_WAIT);
  assign issue = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      ack_ref_q <= 1'b0;
      done      <= 1'b0;
      err_busy  <= 1'b0;
    end else begin
      done     <= 1'b0;
      err_busy <= start && busy;
      if (issue) begin
        phase_q   <= PH_WAIT;
        ack_ref_q <= ack_s;
      end else if (busy && (ack_s != ack_ref_q)) begin
        phase_q <= PH_IDLE;
        done    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmd_toggle_issuer.sv
module cmd_toggle_issuer
  import cti_pkg::*;
#(
  parameter int CODE_W      = 5,
  parameter int SF_W        = 2,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CTRL_W = CODE_W + 1 + SF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  input  logic              sf_load,
  input  logic [SF_W-1:0]   sf_val,
  input  logic [TMO_W-1:0]  timeout_limit,
  input  logic [FAR_W-1:0]  far_status,
  output logic [CTRL_W-1:0] ctrl_byte,
  output logic              busy,
  output logic              done,
  output logic              err_busy,
  output logic              timeout,
  output logic              fifo_nempty
);
  logic [FAR_W-1:0] far_s;
  logic             issue;

  cti_sync #(.W(FAR_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(far_status), .q(far_s)
  );

  cti_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .ack_s(far_s[FAR_ACK]),
    .issue(issue), .busy(busy), .done(done), .err_busy(err_busy)
  );

  cti_ctrl_reg #(.CODE_W(CODE_W), .SF_W(SF_W)) u_ctrl (
    .clk(clk), .rst(rst), .issue(issue), .code(code),
    .sf_load(sf_load), .sf_val(sf_val), .ctrl(ctrl_byte)
  );

  cti_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst(rst), .clear(issue), .run(busy),
    .limit(timeout_limit), .expired(timeout)
  );

  assign fifo_nempty = far_s[FAR_FNE];
endmodule

// File: rtl/cmd_toggle_issuer_chk.sv
module cmd_toggle_issuer_chk #(
  parameter int CODE_W = 5,
  parameter int SF_W   = 2,
  localparam int CTRL_W = CODE_W + 1 + SF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              sf_load,
  input logic [CTRL_W-1:0] ctrl_byte,
  input logic              busy,
  input logic              done,
  input logic              err_busy,
  input logic              timeout
);
  a_r2_edge_flips: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (ctrl_byte[CODE_W] != $past(ctrl_byte[CODE_W])));

  a_r1_code_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ctrl_byte[CODE_W-1:0]));

  a_r3_sf_held: assert property (@(posedge clk) disable iff (rst)
    !sf_load |=> $stable(ctrl_byte[CTRL_W-1:CODE_W+1]));

  a_r6_reject_pulse: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> err_busy);

  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_timeout_sticky: assert property (@(posedge clk) disable iff (rst)
    timeout |=> timeout);
endmodule

bind cmd_toggle_issuer cmd_toggle_issuer_chk #(.CODE_W(CODE_W), .SF_W(SF_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .sf_load(sf_load), .ctrl_byte(ctrl_byte),
  .busy(busy), .done(done), .err_busy(err_busy), .timeout(timeout)
);

// File: tb/cmd_toggle_issuer_test.sv
`timescale 1ns/1ps
module cmd_toggle_issuer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [4:0] code = '0;
  logic       sf_load = 1'b0;
  logic [1:0] sf_val = '0;
  logic [15:0] timeout_limit = 16'd20;
  logic [1:0] far_status;
  logic [7:0] ctrl_byte;
  logic busy, done, err_busy, timeout, fifo_nempty;

  int total = 0;
  int bad = 0;

  // Far-side model: reacts to a change of the edge bit, toggles ack after a delay.
  logic far_ack, last_e, mute, kick, fifo_drv;
  int   cnt;

  initial begin mute = 1'b0; kick = 1'b0; fifo_drv = 1'b0; end

  function automatic int dly_of(logic [4:0] c);
    return c[4] ? 2 + int'(c[1:0]) : 1;
  endfunction

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      far_ack <= 1'b0; last_e <= 1'b0; cnt <= 0;
    end else begin
      last_e <= ctrl_byte[5];
      if (last_e != ctrl_byte[5]) cnt <= mute ? 0 : dly_of(ctrl_byte[4:0]);
      else if (cnt > 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) far_ack <= ~far_ack;
      end
    end
  end

  assign far_status = {fifo_drv, far_ack ^ kick};

  cmd_toggle_issuer uut (
    .clk(clk), .rst(rst), .start(start), .code(code), .sf_load(sf_load),
    .sf_val(sf_val), .timeout_limit(timeout_limit), .far_status(far_status),
    .ctrl_byte(ctrl_byte), .busy(busy), .done(done), .err_busy(err_busy),
    .timeout(timeout), .fifo_nempty(fifo_nempty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic       exp_edge;
  logic [1:0] exp_sf;
  int         n;

  initial begin
    exp_edge = 1'b0;
    exp_sf = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(ctrl_byte == 8'h00, "R9 ctrl", ctrl_byte, 0);
    check({busy, done, err_busy, timeout} == 4'b0, "R9 flags",
          {busy, done, err_busy, timeout}, 0);

    // R7 FIFO flag latency
    fifo_drv = 1'b1;
    @(negedge clk);
    check(fifo_nempty == 1'b0, "R7 one edge", fifo_nempty, 0);
    @(negedge clk);
    check(fifo_nempty == 1'b1, "R7 two edges", fifo_nempty, 1);
    fifo_drv = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(fifo_nempty == 1'b0, "R7 fall", fifo_nempty, 0);

    // Sweep all codes
    for (int c = 0; c < 32; c++) begin
      sf_load = 1'b1; sf_val = 2'(c % 4) ^ 2'b10;
      @(negedge clk);
      sf_load = 1'b0; exp_sf = 2'(c % 4) ^ 2'b10;
      check(ctrl_byte[7:6] == exp_sf, "R3 load", ctrl_byte[7:6], exp_sf);
      start = 1'b1; code = 5'(c);
      @(negedge clk);
      start = 1'b0; code = ~5'(c);
      exp_edge = ~exp_edge;
      check(ctrl_byte[4:0] == 5'(c), "R1 code", ctrl_byte[4:0], c);
      check(ctrl_byte[5] == exp_edge, "R2 edge", ctrl_byte[5], exp_edge);
      check(ctrl_byte[7:6] == exp_sf, "R3 kept", ctrl_byte[7:6], exp_sf);
      check(busy == 1'b1, "R5 busy rise", busy, 1);
      n = 0;
      if (c % 5 == 0) begin
        start = 1'b1;
        @(negedge clk); n = 1;
        start = 1'b0;
        check(err_busy == 1'b1, "R6 reject pulse", err_busy, 1);
        check(ctrl_byte[5:0] == {exp_edge, 5'(c)}, "R6 ctrl untouched",
              ctrl_byte[5:0], {exp_edge, 5'(c)});
      end
      while (n < 60) begin
        @(negedge clk); n++;
        if (done) break;
        check(busy == 1'b1, "R5 busy held", busy, 1);
      end
      check(n == 4 + dly_of(5'(c)), "R4 done cycle", n, 4 + dly_of(5'(c)));
      check(busy == 1'b0 && timeout == 1'b0, "R5 busy clear", {busy, timeout}, 0);
      @(negedge clk);
      check(done == 1'b0 && err_busy == 1'b0, "R4 single pulse", {done, err_busy}, 0);
    end

    // R8 timeout with the far side silent
    timeout_limit = 16'd5;
    mute = 1'b1;
    start = 1'b1; code = 5'h03;
    @(negedge clk);
    start = 1'b0;
    exp_edge = ~exp_edge;
    check(ctrl_byte[5] == exp_edge, "R2 edge again", ctrl_byte[5], exp_edge);
    repeat (5) @(negedge clk);
    check(timeout == 1'b0, "R8 before limit", timeout, 0);
    @(negedge clk);
    check(timeout == 1'b1, "R8 at limit", timeout, 1);
    repeat (4) @(negedge clk);
    check(timeout && busy, "R8 sticky and still busy", {timeout, busy}, 3);

    // Late acknowledge still completes (R5, R8)
    mute = 1'b0;
    kick = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R4 not yet", done, 0);
    @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R5 late ack", {done, busy}, 2);
    check(timeout == 1'b1, "R8 flag kept", timeout, 1);

    // Reference now 1: next command completes on the change back (R5)
    timeout_limit = 16'd20;
    @(negedge clk);
    start = 1'b1; code = 5'h01;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (n < 60) begin
      @(negedge clk); n++;
      if (done) break;
    end
    check(n == 5, "R5 relative level", n, 5);

    // R9 reset clears timeout and edge
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(timeout == 1'b0 && busy == 1'b0, "R9 clear flags", {timeout, busy}, 0);
    check(ctrl_byte == 8'h00, "R9 clear ctrl", ctrl_byte, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule